// File: doc/BRIEF.md
# Master Interrupt Mask and Router

The router watches 32 level-sensitive system interrupt lines. It keeps a pending register that tracks the lines and a disable register that masks them. Each line has a constant 4-bit priority level, fixed when the block is elaborated. Lines whose level is zero are never recorded. The pending bits that are not disabled make up the effective set. The levels of that set are merged into one 16-bit vector, and the vector is delivered to a single target processor chosen by software. Every other processor sees an all-zero vector. Disable bit 31 is a global switch: when it is set, nothing is delivered.

Software reaches the block through five word registers, selected by byte-address bits 4:2:
- index 0 reads pending.
- index 1 reads the disabled mask.
- index 2 enables sources by clearing their disable bits.
- index 3 disables sources. The same write also drops their pending bits.
- index 4 holds the target processor number.

A group of bits, given by the constant 0x0FA2007F, is reserved. These bits stay disabled for good, and they read as zero in the disabled view.

Each time a line with a nonzero level changes, the block emits a one-cycle set or clear mask toward the local pending bit of that level on the current target processor.

Top module: `irq_router`

## Requirements
- R1: After reset, index 0, index 1 and index 4 read zero, every routed vector is zero, and both notify masks are zero. The disabled register resets to 0x0FA2007F.
- R2: A source whose level is nonzero changes its pending bit to match its input level, as sampled at a clock edge. A source with level zero never sets its pending bit.
- R3: A read at index 0 returns pending with bit 31 forced to 0. A read at index 1 returns the disabled register ANDed with 0xF05DFF80.
- R4: A write at index 2 clears the disable bits where the data is 1, but only in bits outside 0x0FA2007F. Reserved bits stay disabled.
- R5: A write at index 3 sets the disable bits where the data is 1, outside 0x0FA2007F. The same write clears those bits in pending.
- R6: A write at index 4 loads data bits 3:0 as the target processor and ignores the higher data bits. A read at index 4 returns the target number, zero-extended.
- R7: Let the effective set be pending AND NOT disabled. If it is nonzero and disable bit 31 is clear, the target's vector (bits 16*t+15 down to 16*t of the output) is the OR of (1 << level) over the effective bits. All other vectors are zero.
- R8: While disable bit 31 is set, all routed vectors are zero, and pending keeps tracking the inputs.
- R9: In the cycle after an edge that sees nonzero-level sources rise or fall, the set mask is the OR of (1 << level) over the rising sources. The clear mask is the same OR over the falling sources, minus the set-mask bits. The cpu output gives the target that was in force at that edge.
- R10: Reads at indices 5 to 7 return zero. Writes at indices 0, 1, 5, 6 and 7 change no state.
- R11: If a source changes at the same edge as an index-3 write covering its bit, the write wins and the pending bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 32 | System interrupt source levels |
| bus_idx | input | 3 | Register index (byte address bits 4:2) |
| bus_wr_en | input | 1 | Write strobe for the selected index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected index, combinational |
| cpu_level_vec | output | 16*N_CPU | Routed level vector, 16 bits per processor |
| lp_set_mask | output | 16 | Levels to set in the target's local pending |
| lp_clr_mask | output | 16 | Levels to clear in the target's local pending |
| lp_cpu | output | log2(N_CPU) | Processor that the notify masks address |

## Verification
Read data is combinational, so each read is sampled a short delay after the index is applied, with no clock edge in between. Pending, disabled and target are updated at the rising edge that samples a write or a source change. The routed vectors come straight from those registers, and the notify masks are registered at the same edge, so all of them are due one edge after the stimulus. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares at the next falling edge against its own register model. It updates that model at the rising edge, using the old target for the notify cpu.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC = 32;
  localparam int LVW  = 4;
  localparam int NLVL = 1 << LVW;
  localparam int DW   = 32;

  localparam logic [2:0] IDX_PEND = 3'd0;
  localparam logic [2:0] IDX_DIS  = 3'd1;
  localparam logic [2:0] IDX_EN   = 3'd2;
  localparam logic [2:0] IDX_OFF  = 3'd3;
  localparam logic [2:0] IDX_TGT  = 3'd4;

  typedef logic [NSRC*LVW-1:0] level_map_t;

  // level assigned to source i
  function automatic logic [LVW-1:0] level_of(input level_map_t map, input int i);
    return map[i*LVW +: LVW];
  endfunction

  // OR of (1 << level) over the set bits
  function automatic logic [NLVL-1:0] levels_to_mask(input level_map_t map,
                                                     input logic [NSRC-1:0] bits);
    logic [NLVL-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++)
      if (bits[i]) m = m | (NLVL'(1) << level_of(map, i));
    return m;
  endfunction

  // sources whose level is nonzero
  function automatic logic [NSRC-1:0] live_sources(input level_map_t map);
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) v[i] = (level_of(map, i) != '0);
    return v;
  endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter level_map_t  LEVEL_MAP = '0,
  parameter logic [31:0] RSVD_MASK = 32'h0FA2_007F,
  parameter int          CW        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [2:0]      idx,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] dis_q,
  output logic [CW-1:0]   tgt_q,
  output logic [NSRC-1:0] rise,
  output logic [NSRC-1:0] fall,
  output logic            wr_en_ev,
  output logic            wr_off_ev,
  output logic            wr_tgt_ev
);
  localparam logic [NSRC-1:0] LIVE = live_sources(LEVEL_MAP);

  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] wmask;
  logic [NSRC-1:0] pend_n;
  logic [NSRC-1:0] dis_n;

  assign wr_en_ev  = wr_en && (idx == IDX_EN);
  assign wr_off_ev = wr_en && (idx == IDX_OFF);
  assign wr_tgt_ev = wr_en && (idx == IDX_TGT);
  assign wmask     = wdata & ~RSVD_MASK;

  assign rise = src & ~src_q & LIVE;
  assign fall = ~src & src_q & LIVE;

  always_comb begin
    pend_n = (pend_q & ~(rise | fall)) | rise;
    if (wr_off_ev) pend_n = pend_n & ~wmask;
    dis_n = dis_q;
    if (wr_en_ev)  dis_n = dis_q & ~wmask;
    if (wr_off_ev) dis_n = dis_q | wmask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      dis_q  <= RSVD_MASK;
      tgt_q  <= '0;
    end else begin
      src_q  <= src;
      pend_q <= pend_n;
      dis_q  <= dis_n;
      if (wr_tgt_ev) tgt_q <= wdata[CW-1:0];
    end
  end

  always_comb begin
    case (idx)
      IDX_PEND: rdata = pend_q & 32'h7FFF_FFFF;
      IDX_DIS:  rdata = dis_q & ~RSVD_MASK;
      IDX_TGT:  rdata = {{(DW-CW){1'b0}}, tgt_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_notify.sv
module irq_router_notify
  import irq_router_pkg::*;
#(
  parameter level_map_t LEVEL_MAP = '0,
  parameter int         CW        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rise,
  input  logic [NSRC-1:0] fall,
  input  logic [CW-1:0]   tgt,
  output logic [NLVL-1:0] set_mask,
  output logic [NLVL-1:0] clr_mask,
  output logic [CW-1:0]   cpu
);
  logic [NLVL-1:0] set_n;
  logic [NLVL-1:0] clr_n;

  assign set_n = levels_to_mask(LEVEL_MAP, rise);
  assign clr_n = levels_to_mask(LEVEL_MAP, fall) & ~set_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_mask <= '0;
      clr_mask <= '0;
      cpu      <= '0;
    end else begin
      set_mask <= set_n;
      clr_mask <= clr_n;
      cpu      <= tgt;
    end
  end
endmodule

// File: rtl/irq_router_steer.sv
module irq_router_steer
  import irq_router_pkg::*;
#(
  parameter level_map_t LEVEL_MAP = '0,
  parameter int         N_CPU     = 16,
  parameter int         CW        = 4
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC-1:0]       dis,
  input  logic [CW-1:0]         tgt,
  output logic [N_CPU*NLVL-1:0] vec
);
  logic [NSRC-1:0] eff;
  logic            route_ok;
  logic [NLVL-1:0] lvls;

  assign eff      = pend & ~dis;
  assign route_ok = (|eff) && !dis[NSRC-1];
  assign lvls     = levels_to_mask(LEVEL_MAP, eff);

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    assign vec[c*NLVL +: NLVL] = (route_ok && tgt == CW'(c)) ? lvls : '0;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int          N_CPU     = 16,
  parameter level_map_t  LEVEL_MAP = 128'hF123456789ABCDEF_FEDCBA9876543210,
  parameter logic [31:0] RSVD_MASK = 32'h0FA2_007F
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [31:0]               src_irq,
  input  logic [2:0]                bus_idx,
  input  logic                      bus_wr_en,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [N_CPU*16-1:0]       cpu_level_vec,
  output logic [15:0]               lp_set_mask,
  output logic [15:0]               lp_clr_mask,
  output logic [$clog2(N_CPU)-1:0]  lp_cpu
);
  localparam int CW = $clog2(N_CPU);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] dis_q;
  logic [CW-1:0]   tgt_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] fall;
  logic            wr_en_ev;
  logic            wr_off_ev;
  logic            wr_tgt_ev;

  irq_router_regs #(.LEVEL_MAP(LEVEL_MAP), .RSVD_MASK(RSVD_MASK), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .src(src_irq), .idx(bus_idx), .wr_en(bus_wr_en),
    .wdata(bus_wdata), .rdata(bus_rdata), .pend_q(pend_q), .dis_q(dis_q),
    .tgt_q(tgt_q), .rise(rise), .fall(fall), .wr_en_ev(wr_en_ev),
    .wr_off_ev(wr_off_ev), .wr_tgt_ev(wr_tgt_ev)
  );

  irq_router_notify #(.LEVEL_MAP(LEVEL_MAP), .CW(CW)) u_notify (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .tgt(tgt_q),
    .set_mask(lp_set_mask), .clr_mask(lp_clr_mask), .cpu(lp_cpu)
  );

  irq_router_steer #(.LEVEL_MAP(LEVEL_MAP), .N_CPU(N_CPU), .CW(CW)) u_steer (
    .pend(pend_q), .dis(dis_q), .tgt(tgt_q), .vec(cpu_level_vec)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int          N_CPU     = 16,
  parameter level_map_t  LEVEL_MAP = '0,
  parameter logic [31:0] RSVD_MASK = 32'h0FA2_007F,
  parameter int          CW        = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            bus_idx,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [N_CPU*16-1:0]   cpu_level_vec,
  input logic [15:0]           lp_set_mask,
  input logic [15:0]           lp_clr_mask,
  input logic [NSRC-1:0]       pend_q,
  input logic [NSRC-1:0]       dis_q,
  input logic [CW-1:0]         tgt_q,
  input logic                  wr_off_ev,
  input logic                  wr_tgt_ev
);
  localparam logic [NSRC-1:0] DEAD = ~live_sources(LEVEL_MAP);

  logic other_nz;
  always_comb begin
    other_nz = 1'b0;
    for (int c = 0; c < N_CPU; c++)
      if (CW'(c) != tgt_q) other_nz = other_nz | (|cpu_level_vec[c*16 +: 16]);
  end

  a_r2_dead_never_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & DEAD) == '0);
  a_r3_pend_top_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idx == IDX_PEND) |-> !bus_rdata[31]);
  a_r4_reserved_stick: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q & RSVD_MASK) == RSVD_MASK);
  a_r5_off_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off_ev |=> ((pend_q & $past(bus_wdata & ~RSVD_MASK)) == '0));
  a_r6_target_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgt_ev |=> (tgt_q == $past(bus_wdata[CW-1:0])));
  a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    !other_nz);
  a_r8_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q[31] |-> (cpu_level_vec == '0));
  a_r9_masks_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_set_mask & lp_clr_mask) == '0);
endmodule

bind irq_router irq_router_chk #(
  .N_CPU(N_CPU), .LEVEL_MAP(LEVEL_MAP), .RSVD_MASK(RSVD_MASK), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cpu_level_vec(cpu_level_vec),
  .lp_set_mask(lp_set_mask), .lp_clr_mask(lp_clr_mask), .pend_q(pend_q),
  .dis_q(dis_q), .tgt_q(tgt_q), .wr_off_ev(wr_off_ev), .wr_tgt_ev(wr_tgt_ev)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  localparam int NC = 16;
  localparam logic [31:0] RSV = 32'h0FA2_007F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src_irq = '0;
  logic [2:0]  bus_idx = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC*16-1:0] cpu_level_vec;
  logic [15:0] lp_set_mask, lp_clr_mask;
  logic [3:0]  lp_cpu;

  irq_router dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_idx(bus_idx),
    .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_level_vec(cpu_level_vec), .lp_set_mask(lp_set_mask),
    .lp_clr_mask(lp_clr_mask), .lp_cpu(lp_cpu)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_pend, m_dis, m_srcq;
  logic [3:0]  m_tgt, e_cpu;
  logic [15:0] e_set, e_clr;

  // level table restated: low half counts up, upper half counts down, top source at 15
  function automatic int lvl(int i);
    if (i < 16) return i;
    if (i == 31) return 15;
    return 31 - i;
  endfunction

  function automatic logic [15:0] lvset(logic [31:0] b);
    logic [15:0] m = '0;
    for (int i = 0; i < 32; i++) if (b[i] && lvl(i) != 0) m[lvl(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [NC*16-1:0] exp_vec();
    logic [NC*16-1:0] v = '0;
    logic [31:0] eff = m_pend & ~m_dis;
    if (eff != 0 && !m_dis[31]) v[m_tgt*16 +: 16] = lvset(eff);
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic rd(logic [2:0] idx, logic [31:0] expv, string req);
    bus_wr_en = 1'b0;
    bus_idx = idx;
    #1;
    chk(bus_rdata === expv, req, 256'(bus_rdata), 256'(expv));
  endtask

  // one clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(logic [31:0] s, bit wr, logic [2:0] idx, logic [31:0] d, string req);
    logic [31:0] live, r, f, wm;
    src_irq = s; bus_wr_en = wr; bus_idx = idx; bus_wdata = d;
    @(posedge clk);
    live = '0;
    for (int i = 0; i < 32; i++) live[i] = (lvl(i) != 0);
    r = s & ~m_srcq & live;
    f = ~s & m_srcq & live;
    wm = d & ~RSV;
    e_set = lvset(r);
    e_clr = lvset(f) & ~e_set;
    e_cpu = m_tgt;
    m_pend = (m_pend & ~(r | f)) | r;
    if (wr && idx == 3'd3) begin m_pend &= ~wm; m_dis |= wm; end
    if (wr && idx == 3'd2) m_dis &= ~wm;
    if (wr && idx == 3'd4) m_tgt = d[3:0];
    m_srcq = s;
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk(cpu_level_vec === exp_vec(), {req, " R7 vector"}, 256'(cpu_level_vec), 256'(exp_vec()));
    chk(lp_set_mask === e_set && lp_clr_mask === e_clr, {req, " R9 masks"},
        256'({lp_set_mask, lp_clr_mask}), 256'({e_set, e_clr}));
    if (e_set != 0 || e_clr != 0)
      chk(lp_cpu === e_cpu, {req, " R9 cpu"}, 256'(lp_cpu), 256'(e_cpu));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd20240917));
    m_pend = '0; m_dis = RSV; m_srcq = '0; m_tgt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 32'h0, "R1 pending");
    rd(3'd1, 32'h0, "R1 disabled view");
    rd(3'd4, 32'h0, "R1 target");
    chk(cpu_level_vec === '0 && lp_set_mask === '0 && lp_clr_mask === '0, "R1 outputs",
        256'(cpu_level_vec), 256'(0));
    // R2 R7 R9: source 8 rises, routed to cpu 0
    s = 32'h0000_0100;
    step(s, 0, 0, 0, "R2 rise");
    rd(3'd0, m_pend, "R2 pending follows");
    // R2: level-zero source 0 ignored
    s |= 32'h1;
    step(s, 0, 0, 0, "R2 level0");
    rd(3'd0, 32'h0000_0100, "R2 level0 ignored");
    // R6: target write with upper bits
    step(s, 1, 3'd4, 32'h0000_0035, "R6 target");
    rd(3'd4, 32'h5, "R6 readback");
    // R8: master disable through bit 31
    step(s, 1, 3'd3, 32'h8000_0000, "R8 off");
    rd(3'd1, 32'h8000_0000, "R8 disabled view");
    s |= 32'h8000_0000;
    step(s, 0, 0, 0, "R8 source while off");
    rd(3'd0, 32'h0000_0100, "R3 bit31 hidden");
    step(s, 1, 3'd2, 32'h8000_0000, "R8 on again");
    // R11: change and disable in the same edge
    s |= 32'h0000_0400;
    step(s, 1, 3'd3, 32'h0000_0400, "R11 collide");
    rd(3'd0, 32'h0000_0100, "R11 write wins");
    // R5: disable drops pending of source 8
    step(s, 1, 3'd3, 32'h0000_0100, "R5 off");
    rd(3'd0, 32'h0, "R5 pending dropped");
    // R4: enable all, reserved stay hidden and blocked
    step(s, 1, 3'd2, 32'hFFFF_FFFF, "R4 enable all");
    rd(3'd1, 32'h0, "R4 disabled view");
    s |= 32'h0000_0008;
    step(s, 0, 0, 0, "R4 reserved source");
    rd(3'd0, m_pend & 32'h7FFF_FFFF, "R3 pending view");
    // R10: unlisted or read-only indices ignore writes
    step(s, 1, 3'd5, 32'hFFFF_FFFF, "R10 idx5");
    step(s, 1, 3'd7, 32'h0000_000F, "R10 idx7");
    step(s, 1, 3'd0, 32'hFFFF_FFFF, "R10 idx0");
    step(s, 1, 3'd1, 32'h0000_0000, "R10 idx1");
    rd(3'd5, 32'h0, "R10 read5");
    rd(3'd6, 32'h0, "R10 read6");
    rd(3'd7, 32'h0, "R10 read7");
    rd(3'd1, m_dis & ~RSV, "R10 disabled kept");
    rd(3'd4, 32'(m_tgt), "R10 target kept");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 10;
      logic [31:0] d = $urandom;
      s = s ^ (32'h1 << ($urandom % 32)) ^ (($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0);
      case (op)
        0: step(s, 1, 3'd2, d, "rnd R4");
        1: step(s, 1, 3'd3, d & $urandom & $urandom, "rnd R5");
        2: step(s, 1, 3'd4, d, "rnd R6");
        3: step(s, 1, 3'(5 + $urandom % 3), d, "rnd R10");
        default: step(s, 0, 3'd0, 0, "rnd R2");
      endcase
      if (n % 8 == 0) begin
        rd(3'd0, m_pend & 32'h7FFF_FFFF, "rnd R3 pending");
        rd(3'd1, m_dis & ~RSV, "rnd R3 disabled");
        rd(3'd4, 32'(m_tgt), "rnd R6 target");
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule